// File: doc/BRIEF.md
# Clock Divider Ratio Control Register

This block holds the divider settings for six clock domains in one 16-bit control word: peripheral, display (LCD), processor, signal-processor, signal-processor memory-management unit and system bus. Each domain has a 2-bit exponent e, and that domain runs at the common input clock rate divided by 2^e. Software writes a whole word through a write port. Before the value is stored, combinational correction logic adjusts it so the domains keep a legal frequency ordering. The stored word can be read back at any time.

The correction runs as a fixed chain of clamps:

- The memory-management-unit exponent is pulled into the window from the signal-processor exponent up to that exponent plus one.
- The bus exponent is raised to at least the processor exponent, and then to at least the corrected memory-management-unit exponent.
- The display and peripheral exponents are raised to at least the final bus exponent.

Only the relative ordering of the domains is enforced. No absolute frequency limit is checked.

The block also turns the stored exponents into six enable strobes, one per domain. Each strobe is high for one input-clock cycle out of every 2^e cycles. When a write changes a domain's exponent, that domain's strobe counter restarts from the new setting. Because of this restart, the strobe never fires after a shortened period.

Top module: `clkdiv_ratio_ctl`

## Requirements
- R1: After reset the stored word reads 16'h0000 and all six strobes are high.
- R2: When wr_en_i is high at a clock edge, rd_data_o shows the corrected word from the next cycle on. When wr_en_i is low, rd_data_o does not change.
- R3: Field layout is peripheral [1:0], display [3:2], processor [5:4], signal processor [7:6], bus [9:8], memory-management unit [11:10]. The stored memory-management-unit exponent equals the written one limited to the range from the signal-processor exponent to the signal-processor exponent plus one.
- R4: The stored bus exponent is the largest of the written bus exponent, the written processor exponent and the corrected memory-management-unit exponent.
- R5: The stored display and peripheral exponents are each the larger of their written value and the stored bus exponent.
- R6: Bits [15:12] of the written word are stored unchanged.
- R7: The processor and signal-processor exponents are stored exactly as written.
- R8: A domain with stored exponent e strobes once every 2^e cycles, so any 64-cycle window holds exactly 64/2^e strobes. With e = 0 the strobe stays high.
- R9: When a write changes a domain's exponent to e, counting the first cycle after the write edge as cycle 0, that domain's strobe is low in cycles 0 to 2^e-2 and high in cycle 2^e-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Write strobe for the control word |
| wr_data_i | input | 16 | Word to be corrected and stored |
| rd_data_o | output | 16 | Stored (corrected) control word |
| tick_o | output | 6 | Per-domain enable strobes, bit index = field index (0 peripheral ... 5 memory-management unit) |

## Verification
The bench writes every combination of the twelve exponent bits, with varying upper bits, and compares each field with its own arithmetic model of the clamp chain. Three kinds of error are exposed this way:

- A design that applied the clamps in another order would store a bus exponent below the corrected memory-management-unit exponent.
- A design that dropped the upper clamp would leave the memory-management unit more than one step slower than the signal processor.
- A design that swapped two fields would misplace the processor or signal-processor exponent.

The strobe checks watch the first period after an exponent change, and would catch a counter that kept its old count and fired early. The steady-state windows catch a wrong period or a reload that was off by one.

// File: rtl/ckdiv_pkg.sv
package ckdiv_pkg;
  localparam int EXP_W    = 2;
  localparam int NDOM     = 6;
  localparam int REG_W    = 16;
  localparam int PASS_LSB = 12;

  // Field indices; the clamp chain depends on which field is which.
  localparam int F_PER = 0;
  localparam int F_LCD = 1;
  localparam int F_CPU = 2;
  localparam int F_DSP = 3;
  localparam int F_BUS = 4;
  localparam int F_MMU = 5;

  typedef logic [EXP_W:0] exp_wide_t;

  function automatic exp_wide_t field_of(input logic [REG_W-1:0] v, input int idx);
    return {1'b0, v[idx*EXP_W +: EXP_W]};
  endfunction

  function automatic logic [REG_W-1:0] legalize(input logic [REG_W-1:0] raw);
    exp_wide_t e_per, e_lcd, e_cpu, e_dsp, e_bus, e_mmu;
    exp_wide_t step;
    logic [REG_W-1:0] res;
    step  = exp_wide_t'(1);
    e_per = field_of(raw, F_PER);
    e_lcd = field_of(raw, F_LCD);
    e_cpu = field_of(raw, F_CPU);
    e_dsp = field_of(raw, F_DSP);
    e_bus = field_of(raw, F_BUS);
    e_mmu = field_of(raw, F_MMU);
    if (e_mmu < e_dsp)        e_mmu = e_dsp;
    if (e_mmu > e_dsp + step) e_mmu = e_dsp + step;
    if (e_bus < e_cpu)        e_bus = e_cpu;
    if (e_bus < e_mmu)        e_bus = e_mmu;
    if (e_lcd < e_bus)        e_lcd = e_bus;
    if (e_per < e_bus)        e_per = e_bus;
    res = '0;
    res[REG_W-1:PASS_LSB]      = raw[REG_W-1:PASS_LSB];
    res[F_PER*EXP_W +: EXP_W]  = e_per[EXP_W-1:0];
    res[F_LCD*EXP_W +: EXP_W]  = e_lcd[EXP_W-1:0];
    res[F_CPU*EXP_W +: EXP_W]  = e_cpu[EXP_W-1:0];
    res[F_DSP*EXP_W +: EXP_W]  = e_dsp[EXP_W-1:0];
    res[F_BUS*EXP_W +: EXP_W]  = e_bus[EXP_W-1:0];
    res[F_MMU*EXP_W +: EXP_W]  = e_mmu[EXP_W-1:0];
    return res;
  endfunction
endpackage

// File: rtl/ckdiv_legalize.sv
module ckdiv_legalize
  import ckdiv_pkg::*;
(
  input  logic [REG_W-1:0] raw_i,
  output logic [REG_W-1:0] legal_o
);
  assign legal_o = legalize(raw_i);
endmodule

// File: rtl/ckdiv_ctlreg.sv
module ckdiv_ctlreg #(
  parameter int          WIDTH     = 16,
  parameter logic [15:0] RESET_VAL = 16'h0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)    q_o <= WIDTH'(RESET_VAL);
    else if (we_i) q_o <= d_i;
  end
endmodule

// File: rtl/ckdiv_strobe.sv
module ckdiv_strobe #(
  parameter int EXP_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [EXP_W-1:0] new_exp_i,
  input  logic [EXP_W-1:0] cur_exp_i,
  output logic             tick_o
);
  localparam int CNT_W = (1 << EXP_W) - 1;

  function automatic logic [CNT_W-1:0] period_top(input logic [EXP_W-1:0] e);
    logic [CNT_W:0] pw;
    pw = (CNT_W+1)'(1) << e;
    return CNT_W'(pw - (CNT_W+1)'(1));
  endfunction

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load_i)         cnt_q <= period_top(new_exp_i);
    else if (cnt_q == '0)    cnt_q <= period_top(cur_exp_i);
    else                     cnt_q <= cnt_q - CNT_W'(1);
  end

  assign tick_o = (cnt_q == '0);
endmodule

// File: rtl/clkdiv_ratio_ctl.sv
module clkdiv_ratio_ctl
  import ckdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [15:0]      wr_data_i,
  output logic [15:0]      rd_data_o,
  output logic [5:0]       tick_o
);
  logic [REG_W-1:0] legal_w;
  logic [REG_W-1:0] stored_q;
  logic [NDOM-1:0]  field_load;

  ckdiv_legalize u_legal (
    .raw_i   (wr_data_i),
    .legal_o (legal_w)
  );

  ckdiv_ctlreg #(.WIDTH(REG_W), .RESET_VAL(16'h0000)) u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .we_i  (wr_en_i),
    .d_i   (legal_w),
    .q_o   (stored_q)
  );

  for (genvar d = 0; d < NDOM; d++) begin : g_dom
    assign field_load[d] = wr_en_i &&
      (legal_w[d*EXP_W +: EXP_W] != stored_q[d*EXP_W +: EXP_W]);

    ckdiv_strobe #(.EXP_W(EXP_W)) u_strobe (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (field_load[d]),
      .new_exp_i (legal_w[d*EXP_W +: EXP_W]),
      .cur_exp_i (stored_q[d*EXP_W +: EXP_W]),
      .tick_o    (tick_o[d])
    );
  end

  assign rd_data_o = stored_q;
endmodule

// File: rtl/clkdiv_ratio_ctl_chk.sv
module clkdiv_ratio_ctl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en_i,
  input logic [3:0]  wr_hi,
  input logic [3:0]  wr_cd,
  input logic [15:0] rd_data_o,
  input logic [5:0]  tick_o,
  input logic [5:0]  field_load
);
  logic [2:0] c_per, c_lcd, c_cpu, c_dsp, c_bus, c_mmu;
  assign c_per = {1'b0, rd_data_o[1:0]};
  assign c_lcd = {1'b0, rd_data_o[3:2]};
  assign c_cpu = {1'b0, rd_data_o[5:4]};
  assign c_dsp = {1'b0, rd_data_o[7:6]};
  assign c_bus = {1'b0, rd_data_o[9:8]};
  assign c_mmu = {1'b0, rd_data_o[11:10]};

  // R2
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> $stable(rd_data_o));
  // R3
  mmu_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_mmu >= c_dsp) && (c_mmu <= c_dsp + 3'd1));
  // R4
  bus_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_bus >= c_cpu) && (c_bus >= c_mmu));
  // R5
  slow_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_lcd >= c_bus) && (c_per >= c_bus));
  // R6
  upper_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> rd_data_o[15:12] == $past(wr_hi));
  // R7
  cpu_dsp_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> rd_data_o[7:4] == $past(wr_cd));

  for (genvar d = 0; d < 6; d++) begin : g_dom_chk
    // R8
    zero_exp_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data_o[2*d +: 2] == 2'd0) |-> tick_o[d]);
    // R8
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_o[d] && rd_data_o[2*d +: 2] != 2'd0 && !field_load[d]) |=> !tick_o[d]);
    // R9
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      field_load[d] |=> (tick_o[d] == (rd_data_o[2*d +: 2] == 2'd0)));
  end
endmodule

bind clkdiv_ratio_ctl clkdiv_ratio_ctl_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en_i    (wr_en_i),
  .wr_hi      (wr_data_i[15:12]),
  .wr_cd      (wr_data_i[7:4]),
  .rd_data_o  (rd_data_o),
  .tick_o     (tick_o),
  .field_load (field_load)
);

// File: tb/clkdiv_ratio_ctl_tb_top.sv
module clkdiv_ratio_ctl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = 16'h0;
  logic [15:0] rd_data;
  logic [5:0]  tick;
  int checks = 0;
  int errors = 0;
  logic [15:0] model_q = 16'h0;

  always #2.5 clk = ~clk;

  clkdiv_ratio_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .tick_o(tick)
  );

  function automatic int mx(input int a, input int b); return (a > b) ? a : b; endfunction
  function automatic int mn(input int a, input int b); return (a < b) ? a : b; endfunction
  function automatic int fld(input logic [15:0] v, input int i); return (v >> (2*i)) & 3; endfunction

  // Model of the correction, written as max/min arithmetic.
  function automatic logic [15:0] model(input logic [15:0] w);
    int per, lcd, cpu, dsp, bus, mmu;
    per = fld(w,0); lcd = fld(w,1); cpu = fld(w,2);
    dsp = fld(w,3); bus = fld(w,4); mmu = fld(w,5);
    mmu = mn(mx(mmu, dsp), dsp + 1);
    bus = mx(mx(bus, cpu), mmu);
    lcd = mx(lcd, bus);
    per = mx(per, bus);
    return {w[15:12], mmu[1:0], bus[1:0], dsp[1:0], cpu[1:0], lcd[1:0], per[1:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  // Drives at a falling edge; returns at the falling edge after the write edge.
  task automatic do_write(input logic [15:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
    model_q = model(v);
  endtask

  initial begin
    #900000;
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] prev;
    logic [15:0] vals [7];
    int cnt [6];
    vals = '{16'h0FFF, 16'h0000, 16'h3E4B, 16'hC6D1, 16'h0555, 16'h0AAA, 16'h0924};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rd_data == 16'h0, "R1 reset word", rd_data, 0);
    chk(tick == 6'h3F, "R1 reset strobes", tick, 6'h3F);

    // Sweep all exponent combinations.
    for (int i = 0; i < 4096; i++) begin
      logic [15:0] w, m;
      w = {4'(i[3:0] ^ i[11:8] ^ 4'hA), 12'(i)};
      m = model(w);
      do_write(w);
      chk(rd_data == m, "R2 stored word", rd_data, m);
      chk(fld(rd_data,5) == fld(m,5), "R3 mmu exponent", fld(rd_data,5), fld(m,5));
      chk(fld(rd_data,4) == fld(m,4), "R4 bus exponent", fld(rd_data,4), fld(m,4));
      chk(fld(rd_data,1) == fld(m,1) && fld(rd_data,0) == fld(m,0),
          "R5 lcd/periph exponents", rd_data[3:0], m[3:0]);
      chk(rd_data[15:12] == w[15:12], "R6 upper bits", rd_data[15:12], w[15:12]);
      chk(rd_data[7:4] == w[7:4], "R7 cpu/dsp kept", rd_data[7:4], w[7:4]);
    end

    // Writes disabled: data changes must not reach the register.
    prev = rd_data;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      wr_data = 16'h1234 * 16'(k + 3);
      @(negedge clk);
      chk(rd_data == prev, "R2 ignored when idle", rd_data, prev);
    end

    // Restore a known stored value, then strobe tests.
    do_write(16'h0000);
    repeat (2) @(negedge clk);
    for (int v = 0; v < 7; v++) begin
      logic [15:0] old_m, new_m;
      old_m = model_q;
      new_m = model(vals[v]);
      do_write(vals[v]);
      for (int k = 0; k < 16; k++) begin
        for (int d = 0; d < 6; d++) begin
          if (fld(new_m,d) != fld(old_m,d)) begin
            int per_d;
            bit exp_t;
            per_d = 1 << fld(new_m,d);
            exp_t = ((k + 1) % per_d) == 0;
            chk(tick[d] == exp_t, "R9 restart pattern", tick[d], exp_t);
          end
        end
        @(negedge clk);
      end
      for (int d = 0; d < 6; d++) cnt[d] = 0;
      for (int k = 0; k < 64; k++) begin
        for (int d = 0; d < 6; d++) if (tick[d]) cnt[d]++;
        @(negedge clk);
      end
      for (int d = 0; d < 6; d++)
        chk(cnt[d] == 64 >> fld(new_m,d), "R8 strobe rate", cnt[d], 64 >> fld(new_m,d));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule